// File: doc/BRIEF.md
# GPIO Interrupt Detector and Aggregator

This block turns a bank of already-synchronised pin levels into interrupt events. Each pin has a trigger-select bit and an invert bit. Together they pick one of four conditions: rising edge, falling edge, level low or level high. When a pin's condition occurs, a sticky status bit is set. Software clears a status bit by writing 1 to it.

A per-pin enable mask gates the status bits. Every pin that has both its status and its enable bit set is folded into one registered interrupt line toward the parent interrupt controller.

Pins are packed 32 to a word. A small register port gives access to the status words and the enable words. Nothing else is reachable through that port.

Top module: `girq_ctrl`

## Requirements
- R1: With select=0 and invert=0 a pin sets its status bit on the clock edge that follows a cycle in which its level is 1 and was 0 in the cycle before.
- R2: With select=0 and invert=1 a pin sets its status bit on a 1-to-0 transition of its level; a 0-to-1 transition sets nothing.
- R3: With select=1 and invert=0 (level low) the status bit is set on every clock edge while the level is 0, so a clear written during that time leaves the bit set.
- R4: With select=1 and invert=1 (level high) the status bit is set on every clock edge while the level is 1.
- R5: A write to a status word clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R6: When a clear and a new event hit the same status bit on the same edge, the bit ends up set.
- R7: An event sets the status bit whether or not that pin's enable bit is set.
- R8: `irq_o` is a register that equals the OR over all pins of (status AND enable), updated on the same edge as the status bits.
- R9: The address MSB selects the word kind (0 = status, 1 = enable), and the low bits select the word number, which is pin / 32. Within a word, bit pin % 32 belongs to the pin. Enable writes replace the whole word. Read data appears on `bus_rdata_o` one clock after `bus_rd_i`.
- R10: Reset clears every status bit, every enable bit and `irq_o`. On the first edge after reset no edge event is detected, whatever the pin levels.
- R11: Bit positions for pins NUM_PINS and above read 0 and cannot be set. Word numbers beyond the last word read 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| pin_lvl_i | input | NUM_PINS | Synchronised pin levels |
| trig_sel_i | input | NUM_PINS | Per-pin trigger select (0 edge, 1 level) |
| trig_inv_i | input | NUM_PINS | Per-pin invert (falling edge / level high) |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_addr_i | input | ADDR_W | {kind, word number} |
| bus_wdata_i | input | WORD_W | Write data |
| bus_rdata_o | output | WORD_W | Registered read data |
| irq_o | output | 1 | Aggregated interrupt request |

## Verification
The bench covers the following corner cases, each of which exposes a specific bug:
- A clear written while a level condition still holds: a design that let the clear win would drop a live level interrupt.
- A clear and an edge landing on the same edge: a design with the wrong priority would lose that event.
- A pin held high through reset: a design whose previous-level register is not primed would report a rising edge that never happened.
- Writes of all ones to the partial last word, and reads of a word number past the end: a design that got these wrong would return phantom bits or aliased data.
- A status bit set on a disabled pin: this checks that the status bit still records the event while the interrupt line stays low.

// File: rtl/girq_pkg.sv
package girq_pkg;

  localparam int unsigned WORD_BITS = 32;

  // encoding is {select, invert}
  typedef enum logic [1:0] {
    TRIG_RISE = 2'b00,
    TRIG_FALL = 2'b01,
    TRIG_LOW  = 2'b10,
    TRIG_HIGH = 2'b11
  } trig_mode_e;

  function automatic logic trig_hit(trig_mode_e mode, logic cur, logic prev, logic armed);
    case (mode)
      TRIG_RISE: trig_hit = armed & ~prev &  cur;
      TRIG_FALL: trig_hit = armed &  prev & ~cur;
      TRIG_LOW:  trig_hit = ~cur;
      default:   trig_hit = cur;
    endcase
  endfunction

endpackage

// File: rtl/girq_detect.sv
module girq_detect #(
  parameter int NUM_PINS = 95
) (
  input  logic                clk_i,
  input  logic                rst_i,
  input  logic [NUM_PINS-1:0] lvl_i,
  input  logic [NUM_PINS-1:0] sel_i,
  input  logic [NUM_PINS-1:0] inv_i,
  output logic [NUM_PINS-1:0] evt_o
);
  import girq_pkg::*;

  logic [NUM_PINS-1:0] prev_q;
  logic                armed_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      prev_q  <= '0;
      armed_q <= 1'b0;
    end else begin
      prev_q  <= lvl_i;
      armed_q <= 1'b1;
    end
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    assign evt_o[p] = trig_hit(trig_mode_e'({sel_i[p], inv_i[p]}),
                               lvl_i[p], prev_q[p], armed_q);
  end

endmodule

// File: rtl/girq_regs.sv
module girq_regs #(
  parameter int NUM_PINS = 95,
  parameter int WORD_W   = 32,
  localparam int NUM_WORDS = (NUM_PINS + WORD_W - 1) / WORD_W,
  localparam int IDX_W     = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
  localparam int ADDR_W    = IDX_W + 1,
  localparam int TOT_W     = NUM_WORDS * WORD_W
) (
  input  logic                clk_i,
  input  logic                rst_i,
  input  logic [NUM_PINS-1:0] evt_i,
  input  logic                wr_i,
  input  logic                rd_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [WORD_W-1:0]   wdata_i,
  output logic [WORD_W-1:0]   rdata_o,
  output logic [TOT_W-1:0]    stat_q_o,
  output logic [TOT_W-1:0]    en_q_o,
  output logic [TOT_W-1:0]    stat_d_o,
  output logic [TOT_W-1:0]    en_d_o
);

  logic [TOT_W-1:0]  stat_q, en_q, stat_d, en_d;
  logic [WORD_W-1:0] stat_word [NUM_WORDS];
  logic [WORD_W-1:0] en_word   [NUM_WORDS];
  logic              kind_en;
  logic [IDX_W-1:0]  idx;
  logic              idx_ok;

  assign kind_en = addr_i[ADDR_W-1];
  assign idx     = addr_i[IDX_W-1:0];
  assign idx_ok  = ({1'b0, idx} < (IDX_W+1)'(NUM_WORDS));

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    logic hit;
    assign hit = wr_i && (idx == IDX_W'(w));
    for (genvar b = 0; b < WORD_W; b++) begin : g_bit
      localparam int P = w * WORD_W + b;
      if (P < NUM_PINS) begin : g_live
        logic clr;
        assign clr       = hit & ~kind_en & wdata_i[b];
        assign stat_d[P] = (stat_q[P] & ~clr) | evt_i[P];
        assign en_d[P]   = (hit & kind_en) ? wdata_i[b] : en_q[P];
      end else begin : g_pad
        assign stat_d[P] = 1'b0;
        assign en_d[P]   = 1'b0;
      end
    end
    assign stat_word[w] = stat_q[w*WORD_W +: WORD_W];
    assign en_word[w]   = en_q[w*WORD_W +: WORD_W];
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      stat_q <= '0;
      en_q   <= '0;
    end else begin
      stat_q <= stat_d;
      en_q   <= en_d;
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      rdata_o <= '0;
    end else if (rd_i) begin
      if (!idx_ok)      rdata_o <= '0;
      else if (kind_en) rdata_o <= en_word[idx];
      else              rdata_o <= stat_word[idx];
    end
  end

  assign stat_q_o = stat_q;
  assign en_q_o   = en_q;
  assign stat_d_o = stat_d;
  assign en_d_o   = en_d;

endmodule

// File: rtl/girq_agg.sv
module girq_agg #(
  parameter int TOT_W = 96
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [TOT_W-1:0] stat_d_i,
  input  logic [TOT_W-1:0] en_d_i,
  output logic             irq_o
);

  always_ff @(posedge clk_i) begin
    if (rst_i) irq_o <= 1'b0;
    else       irq_o <= |(stat_d_i & en_d_i);
  end

endmodule

// File: rtl/girq_ctrl.sv
module girq_ctrl #(
  parameter int NUM_PINS = 95,
  parameter int WORD_W   = girq_pkg::WORD_BITS,
  localparam int NUM_WORDS = (NUM_PINS + WORD_W - 1) / WORD_W,
  localparam int IDX_W     = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
  localparam int ADDR_W    = IDX_W + 1,
  localparam int TOT_W     = NUM_WORDS * WORD_W
) (
  input  logic                clk_i,
  input  logic                rst_i,
  input  logic [NUM_PINS-1:0] pin_lvl_i,
  input  logic [NUM_PINS-1:0] trig_sel_i,
  input  logic [NUM_PINS-1:0] trig_inv_i,
  input  logic                bus_wr_i,
  input  logic                bus_rd_i,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic [WORD_W-1:0]   bus_wdata_i,
  output logic [WORD_W-1:0]   bus_rdata_o,
  output logic                irq_o
);

  logic [NUM_PINS-1:0] evt_w;
  logic [TOT_W-1:0]    stat_w, en_w, stat_nx, en_nx;

  girq_detect #(.NUM_PINS(NUM_PINS)) u_detect (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .lvl_i (pin_lvl_i),
    .sel_i (trig_sel_i),
    .inv_i (trig_inv_i),
    .evt_o (evt_w)
  );

  girq_regs #(.NUM_PINS(NUM_PINS), .WORD_W(WORD_W)) u_regs (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .evt_i    (evt_w),
    .wr_i     (bus_wr_i),
    .rd_i     (bus_rd_i),
    .addr_i   (bus_addr_i),
    .wdata_i  (bus_wdata_i),
    .rdata_o  (bus_rdata_o),
    .stat_q_o (stat_w),
    .en_q_o   (en_w),
    .stat_d_o (stat_nx),
    .en_d_o   (en_nx)
  );

  girq_agg #(.TOT_W(TOT_W)) u_agg (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .stat_d_i (stat_nx),
    .en_d_i   (en_nx),
    .irq_o    (irq_o)
  );

endmodule

// File: rtl/girq_ctrl_chk.sv
module girq_ctrl_chk #(
  parameter int NUM_PINS = 95,
  parameter int WORD_W   = 32,
  localparam int NUM_WORDS = (NUM_PINS + WORD_W - 1) / WORD_W,
  localparam int IDX_W     = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
  localparam int ADDR_W    = IDX_W + 1,
  localparam int TOT_W     = NUM_WORDS * WORD_W
) (
  input logic                clk_i,
  input logic                rst_i,
  input logic [NUM_PINS-1:0] lvl_i,
  input logic [NUM_PINS-1:0] sel_i,
  input logic [NUM_PINS-1:0] inv_i,
  input logic                wr_i,
  input logic [ADDR_W-1:0]   addr_i,
  input logic [WORD_W-1:0]   wdata_i,
  input logic                irq_i,
  input logic [TOT_W-1:0]    stat_q,
  input logic [TOT_W-1:0]    en_q
);

  logic [NUM_PINS-1:0] prev_c;
  logic                armed_c;
  logic [NUM_PINS-1:0] rise_c, fall_c, low_c, high_c;
  logic [TOT_W-1:0]    clr_c;
  logic [NUM_PINS-1:0] stat_p;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      prev_c  <= '0;
      armed_c <= 1'b0;
    end else begin
      prev_c  <= lvl_i;
      armed_c <= 1'b1;
    end
  end

  assign rise_c = ~sel_i & ~inv_i & lvl_i & ~prev_c;
  assign fall_c = ~sel_i &  inv_i & ~lvl_i & prev_c;
  assign low_c  =  sel_i & ~inv_i & ~lvl_i;
  assign high_c =  sel_i &  inv_i & lvl_i;
  assign stat_p = stat_q[NUM_PINS-1:0];

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_clr
    assign clr_c[w*WORD_W +: WORD_W] =
      (wr_i && !addr_i[ADDR_W-1] && addr_i[IDX_W-1:0] == IDX_W'(w)) ? wdata_i : '0;
  end

  AST_RISE_SETS: assert property (@(posedge clk_i) disable iff (rst_i || !armed_c)
    (|rise_c) |=> ((stat_p & $past(rise_c)) == $past(rise_c))); // R1

  AST_FALL_SETS: assert property (@(posedge clk_i) disable iff (rst_i || !armed_c)
    (|fall_c) |=> ((stat_p & $past(fall_c)) == $past(fall_c))); // R2

  AST_LOW_HOLDS: assert property (@(posedge clk_i) disable iff (rst_i || !armed_c)
    (|low_c) |=> ((stat_p & $past(low_c)) == $past(low_c))); // R3

  AST_HIGH_HOLDS: assert property (@(posedge clk_i) disable iff (rst_i || !armed_c)
    (|high_c) |=> ((stat_p & $past(high_c)) == $past(high_c))); // R4

  AST_W1C_ONLY: assert property (@(posedge clk_i) disable iff (rst_i || !armed_c)
    1'b1 |=> ((~stat_q & $past(stat_q) & ~$past(clr_c)) == '0)); // R5

  AST_IRQ_AGG: assert property (@(posedge clk_i) disable iff (rst_i || !armed_c)
    irq_i == |(stat_q & en_q)); // R8

  AST_RESET_CLEARS: assert property (@(posedge clk_i)
    rst_i |=> (stat_q == '0 && en_q == '0 && !irq_i)); // R10

endmodule

bind girq_ctrl girq_ctrl_chk #(.NUM_PINS(NUM_PINS), .WORD_W(WORD_W)) u_chk (
  .clk_i   (clk_i),
  .rst_i   (rst_i),
  .lvl_i   (pin_lvl_i),
  .sel_i   (trig_sel_i),
  .inv_i   (trig_inv_i),
  .wr_i    (bus_wr_i),
  .addr_i  (bus_addr_i),
  .wdata_i (bus_wdata_i),
  .irq_i   (irq_o),
  .stat_q  (stat_w),
  .en_q    (en_w)
);

// File: tb/girq_ctrl_bench.sv
module girq_ctrl_bench;

  localparam int NP = 95;
  localparam int WW = 32;
  localparam int AW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NP-1:0] lvl = '0;
  logic [NP-1:0] sel = '0;
  logic [NP-1:0] inv = '0;
  logic          wr  = 1'b0;
  logic          rd  = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [WW-1:0] wdata = '0;
  logic [WW-1:0] rdata;
  logic          irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  girq_ctrl #(.NUM_PINS(NP), .WORD_W(WW)) u_girq_ctrl (
    .clk_i       (clk),
    .rst_i       (rst),
    .pin_lvl_i   (lvl),
    .trig_sel_i  (sel),
    .trig_inv_i  (inv),
    .bus_wr_i    (wr),
    .bus_rd_i    (rd),
    .bus_addr_i  (addr),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .irq_o       (irq)
  );

  // vector: {pin[6:0], sel, inv, lvl0, lvl1, en, exp_status}
  localparam logic [12:0] VEC [0:11] = '{
    {7'd5,  1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1},  // R1 rise
    {7'd5,  1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},  // R1 fall ignored
    {7'd40, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1},  // R2 fall
    {7'd40, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0},  // R2 rise ignored
    {7'd70, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1},  // R3 goes low
    {7'd70, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},  // R3 stays high
    {7'd94, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1},  // R4 goes high
    {7'd94, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},  // R4 stays low
    {7'd31, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},  // R7 disabled pin
    {7'd32, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1},  // R4/R9 held high
    {7'd63, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},  // R2 no change
    {7'd0,  1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1}   // R3 clear while held
  };

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [WW-1:0] d);
    wr = 1'b1; addr = a; wdata = d;
    cyc();
    wr = 1'b0; wdata = '0;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic [WW-1:0] d);
    rd = 1'b1; addr = a;
    cyc();
    rd = 1'b0;
    d = rdata;
  endtask

  task automatic chk(input string req, input logic [WW-1:0] act, input logic [WW-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_all();
    for (int w = 0; w < 3; w++) begin
      bus_write({1'b1, 2'(w)}, '0);
      bus_write({1'b0, 2'(w)}, '1);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [WW-1:0] d;
    // R10: pin 3 held high through reset in rising mode
    lvl[3] = 1'b1;
    repeat (3) cyc();
    rst = 1'b0;
    cyc(); cyc();
    chk("R10 irq after reset", {31'd0, irq}, 32'd0);
    bus_read(3'b000, d); chk("R10 status word0 after reset", d, 32'd0);
    bus_read(3'b100, d); chk("R10 enable word0 after reset", d, 32'd0);
    bus_read(3'b010, d); chk("R10 status word2 after reset", d, 32'd0);
    lvl[3] = 1'b0;
    cyc();

    // vector table walk
    for (int i = 0; i < 12; i++) begin
      logic [6:0] pin;
      int w, b;
      logic s, v, l0, l1, en, st;
      {pin, s, v, l0, l1, en, st} = VEC[i];
      w = int'(pin) / 32;
      b = int'(pin) % 32;
      clear_all();
      sel[pin] = s; inv[pin] = v; lvl[pin] = l0;
      bus_write({1'b1, 2'(w)}, WW'(en) << b);
      bus_write({1'b0, 2'(w)}, '1);
      lvl[pin] = l1;
      cyc();
      chk($sformatf("R8 vec%0d irq", i), {31'd0, irq}, {31'd0, st & en});
      bus_read({1'b0, 2'(w)}, d);
      chk($sformatf("R1-4/R9 vec%0d status", i), d, WW'(st) << b);
      lvl[pin] = 1'b0; sel[pin] = 1'b0; inv[pin] = 1'b0;
      cyc();
    end

    // R5: write 0 keeps, write 1 clears; R8 irq follows
    clear_all();
    bus_write(3'b100, 32'h20);
    lvl[5] = 1'b1;
    cyc();
    chk("R8 irq raised", {31'd0, irq}, 32'd1);
    bus_write(3'b000, 32'h0);
    bus_read(3'b000, d); chk("R5 write 0 keeps bit", d, 32'h20);
    bus_write(3'b000, 32'h20);
    chk("R8 irq drops on clear", {31'd0, irq}, 32'd0);
    bus_read(3'b000, d); chk("R5 write 1 clears bit", d, 32'h0);

    // R6: clear and rising edge on the same edge
    lvl[6] = 1'b1;
    bus_write(3'b000, 32'h40);
    bus_read(3'b000, d); chk("R6 event beats clear", d, 32'h40);
    lvl[5] = 1'b0; lvl[6] = 1'b0;
    clear_all();

    // R11: pad bits and out-of-range words
    bus_write(3'b110, '1);
    bus_read(3'b110, d); chk("R11 enable word2 pad bits", d, 32'h7FFF_FFFF);
    bus_write(3'b111, '1);
    bus_read(3'b111, d); chk("R11 enable word3 reads 0", d, 32'h0);
    bus_read(3'b011, d); chk("R11 status word3 reads 0", d, 32'h0);
    sel = '1; inv = '1; lvl = '1;
    cyc();
    bus_read(3'b010, d); chk("R11 status word2 pad bits", d, 32'h7FFF_FFFF);
    bus_read(3'b001, d); chk("R4 status word1 all high", d, 32'hFFFF_FFFF);
    bus_read(3'b100, d); chk("R11 word3 write did not alias", d, 32'h0);
    sel = '0; inv = '0; lvl = '0;
    cyc();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule